// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits at the head of a receive path. It watches the destination address of each incoming frame and decides whether the frame is kept. The address arrives one byte per clock. A start strobe marks the first byte, and a valid qualifier lets the source leave idle cycles between bytes. When the sixth byte has been taken, the block produces a single accept or reject verdict.

The verdict draws on four sources:

- a programmed station address, compared exactly;
- a broadcast rule;
- a 64-bit multicast hash table, indexed by six bits of a CRC-32 over the address;
- a promiscuous override.

A separate mode input can also send unicast addresses through the hash table.

The station address is supplied as a 32-bit low word and a 16-bit high word. The mode bits keep their positions 3 to 5 on a three-bit port.

Top module: `rx_dest_filter`

## Requirements
- R1: While reset is asserted and after it is released, `verdict_valid` and `verdict_accept` are 0 until an address completes. `verdict_accept` is never 1 while `verdict_valid` is 0.
- R2: `verdict_valid` is 1 for exactly the one cycle after the clock edge that takes the sixth address byte. It is 0 in every other cycle.
- R3: Byte 0 is the byte taken with `da_first`. With `filt_mode[4]` clear and `filt_mode[5]` clear, a unicast address (bit 0 of byte 0 clear) is accepted exactly when bytes 0..5 equal `station_hi[15:8]`, `station_hi[7:0]`, `station_lo[31:24]`, `station_lo[23:16]`, `station_lo[15:8]` and `station_lo[7:0]`.
- R4: The all-ones address is accepted when `filt_mode[3]` is 0 and rejected when it is 1. The hash table never affects this address.
- R5: A multicast address is one with bit 0 of byte 0 set that is not all ones. It is accepted exactly when the selected hash bit is 1. The index is bits 31:26 of a CRC-32 register. That register uses polynomial 0x04C11DB7, starts at all ones, and takes bytes 0..5 in order, each least significant bit first. Index 0..31 selects `hash_lo[index]`; index 32..63 selects `hash_hi[index-32]`.
- R6: With both hash words all ones, every multicast address is accepted.
- R7: With `filt_mode[4]` set, a unicast address is also accepted when its hash bit is set.
- R8: With `filt_mode[5]` set, every address is accepted, including broadcast while `filt_mode[3]` is set.
- R9: `da_first` with `da_valid` restarts collection, discarding a partly collected address. Cycles with `da_valid` low are skipped. Valid bytes that follow a completed address without a new `da_first` produce no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| da_first | input | 1 | Marks byte 0 of a destination address (qualified by `da_valid`) |
| da_valid | input | 1 | Address byte present on `da_byte` |
| da_byte | input | 8 | Destination address byte |
| filt_mode | input | 3 (bits 5:3) | [3] reject broadcast, [4] hash check for unicast, [5] accept all |
| station_lo | input | 32 | Station address bytes 2..5, byte 2 in the top lane |
| station_hi | input | 16 | Station address bytes 0..1, byte 0 in the top lane |
| hash_lo | input | 32 | Hash table bits for index 0..31 |
| hash_hi | input | 32 | Hash table bits for index 32..63 |
| verdict_valid | output | 1 | One-cycle pulse after the sixth byte |
| verdict_accept | output | 1 | Accept flag, meaningful with `verdict_valid` |

## Verification
The hardest case to reach from the ports is proving that each of the 64 hash positions is decoded correctly. The index depends on a CRC of the whole address, so the bench cannot aim for a chosen bit directly. Instead it generates many multicast addresses and computes each index with a bit-serial shift-and-xor model. It then loads a table with only that bit set (accept expected), a table with only a neighbouring bit set (reject expected) and a fully set table. Restart and trailing-byte handling are driven by interrupting an address with a new start strobe and by streaming extra valid bytes after a verdict.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int HASH_W     = 64;
  localparam int IDX_W      = $clog2(HASH_W);
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  // One byte through the CRC register, least significant data bit first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int k = 0; k < 8; k++) begin
      fb = r[31] ^ b[k];
      r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] hash_index(input logic [31:0] c);
    return c[31 -: IDX_W];
  endfunction
endpackage

// File: rtl/dfilt_collect.sv
module dfilt_collect
  import dfilt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              da_first,
  input  logic              da_valid,
  input  logic [7:0]        da_byte,
  output logic              last_evt,
  output logic [ADDR_W-1:0] full_addr,
  output logic [31:0]       crc_next
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0]             cnt_q;
  logic [ADDR_BYTES-2:0][7:0]   bytes_q;
  logic [31:0]                  crc_q;
  logic                         take_first, take_more;

  assign take_first = da_valid & da_first;
  assign take_more  = da_valid & ~da_first & (cnt_q != '0) &
                      (cnt_q < CNT_W'(ADDR_BYTES));
  assign last_evt   = take_more & (cnt_q == CNT_W'(ADDR_BYTES - 1));
  assign crc_next   = crc_step_byte(take_first ? CRC_INIT : crc_q, da_byte);

  // Byte 0 sits in the top lane; the final byte comes straight from the input.
  for (genvar i = 0; i < ADDR_BYTES - 1; i++) begin : g_lane
    assign full_addr[ADDR_W-1-8*i -: 8] = bytes_q[i];
  end
  assign full_addr[7:0] = da_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bytes_q <= '0;
      crc_q   <= CRC_INIT;
    end else if (take_first) begin
      cnt_q      <= CNT_W'(1);
      bytes_q[0] <= da_byte;
      crc_q      <= crc_next;
    end else if (take_more) begin
      cnt_q <= cnt_q + CNT_W'(1);
      crc_q <= crc_next;
      for (int i = 1; i < ADDR_BYTES - 1; i++)
        if (cnt_q == CNT_W'(i)) bytes_q[i] <= da_byte;
    end
  end
endmodule

// File: rtl/dfilt_classify.sv
module dfilt_classify
  import dfilt_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [5:3]        filt_mode,
  input  logic [31:0]       station_lo,
  input  logic [15:0]       station_hi,
  input  logic [31:0]       hash_lo,
  input  logic [31:0]       hash_hi,
  output logic              is_bcast,
  output logic              is_mcast,
  output logic              station_hit,
  output logic              hash_hit,
  output logic              accept
);
  logic [ADDR_W-1:0]     station;
  logic [ADDR_BYTES-1:0] lane_eq;
  logic [HASH_W-1:0]     table_bits;

  assign station    = {station_hi, station_lo};
  assign table_bits = {hash_hi, hash_lo};

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_cmp
    assign lane_eq[i] = addr[8*i +: 8] == station[8*i +: 8];
  end

  assign station_hit = &lane_eq;
  assign is_bcast    = &addr;
  assign is_mcast    = addr[ADDR_W-8] & ~is_bcast;
  assign hash_hit    = table_bits[idx];

  always_comb begin
    if (filt_mode[5])      accept = 1'b1;
    else if (is_bcast)     accept = ~filt_mode[3];
    else if (is_mcast)     accept = hash_hit;
    else                   accept = station_hit | (filt_mode[4] & hash_hit);
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import dfilt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        da_first,
  input  logic        da_valid,
  input  logic [7:0]  da_byte,
  input  logic [5:3]  filt_mode,
  input  logic [31:0] station_lo,
  input  logic [15:0] station_hi,
  input  logic [31:0] hash_lo,
  input  logic [31:0] hash_hi,
  output logic        verdict_valid,
  output logic        verdict_accept
);
  logic              last_evt;
  logic [ADDR_W-1:0] full_addr;
  logic [31:0]       crc_next;
  logic [IDX_W-1:0]  hidx;
  logic              is_bcast, is_mcast, station_hit, hash_hit, accept_c;

  dfilt_collect u_collect (
    .clk(clk), .rst_n(rst_n), .da_first(da_first), .da_valid(da_valid),
    .da_byte(da_byte), .last_evt(last_evt), .full_addr(full_addr),
    .crc_next(crc_next)
  );

  assign hidx = hash_index(crc_next);

  dfilt_classify u_classify (
    .addr(full_addr), .idx(hidx), .filt_mode(filt_mode),
    .station_lo(station_lo), .station_hi(station_hi),
    .hash_lo(hash_lo), .hash_hi(hash_hi),
    .is_bcast(is_bcast), .is_mcast(is_mcast), .station_hit(station_hit),
    .hash_hit(hash_hit), .accept(accept_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_valid  <= 1'b0;
      verdict_accept <= 1'b0;
    end else begin
      verdict_valid  <= last_evt;
      verdict_accept <= last_evt & accept_c;
    end
  end
endmodule

// File: rtl/dfilt_checker.sv
module dfilt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        last_evt,
  input logic [47:0] full_addr,
  input logic [5:3]  filt_mode,
  input logic [31:0] station_lo,
  input logic [15:0] station_hi,
  input logic        verdict_valid,
  input logic        verdict_accept
);
  a_r1_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> !verdict_accept);

  a_r2_pulse_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> verdict_valid);

  a_r2_no_stray_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !last_evt |=> !verdict_valid);

  a_r3_station_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt && !full_addr[40] && full_addr == {station_hi, station_lo}
    |=> verdict_accept);

  a_r4_bcast_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt && (&full_addr) && filt_mode[3] && !filt_mode[5] |=> !verdict_accept);

  a_r8_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt && filt_mode[5] |=> verdict_accept);
endmodule

bind rx_dest_filter dfilt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .last_evt(last_evt), .full_addr(full_addr),
  .filt_mode(filt_mode), .station_lo(station_lo), .station_hi(station_hi),
  .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
);

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, vld = 1'b0;
  logic [7:0]  din = 8'h00;
  logic [5:3]  mode = 3'b000;
  logic [31:0] st_lo, h_lo = 32'h0, h_hi = 32'h0;
  logic [15:0] st_hi;
  logic        dv, acc;
  int          vectors = 0, miscompares = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  localparam logic [47:0] STATION = 48'h02_1A_3C_55_77_90;
  localparam logic [47:0] OTHER   = 48'h04_22_61_0E_9B_3D;
  localparam logic [47:0] MCAST   = 48'h01_00_5E_12_34_56;

  assign st_hi = STATION[47:32];
  assign st_lo = STATION[31:0];

  always #2 clk = ~clk;

  rx_dest_filter u_dut (
    .clk(clk), .rst_n(rst_n), .da_first(sof), .da_valid(vld), .da_byte(din),
    .filt_mode(mode), .station_lo(st_lo), .station_hi(st_hi),
    .hash_lo(h_lo), .hash_hi(h_hi), .verdict_valid(dv), .verdict_accept(acc)
  );

  // Shift-left form with the feedback folded into bit 0.
  function automatic int ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [7:0]  b;
    logic        cy;
    for (int i = 0; i < 6; i++) begin
      b = a[47-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        cy = c[31] ^ b[0];
        b  = b >> 1;
        c  = c << 1;
        if (cy) c = (c ^ 32'h04C1_1DB6) | 32'h1;
      end
    end
    return int'(c >> 26);
  endfunction

  function automatic logic ref_accept(input logic [47:0] a, input logic [5:3] m,
                                      input logic [31:0] hl, input logic [31:0] hh);
    int   k;
    logic hit;
    k   = ref_idx(a);
    hit = (k >= 32) ? hh[k-32] : hl[k];
    if (m[5]) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return !m[3];
    if (a[40]) return hit;
    return (a == STATION) || (m[4] && hit);
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic next_rand(output logic [47:0] a);
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
    a = lfsr[47:0];
  endtask

  // Returns at the falling edge just after the sixth byte was taken.
  task automatic send(input logic [47:0] a, input int gap);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sof = (i == 0); vld = 1'b1; din = a[47-8*i -: 8];
      if (i < 5)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          check("R2 quiet during stall", dv, 1'b0);
          sof = 1'b0; vld = 1'b0; din = 8'hA5;
        end
    end
    @(negedge clk);
    sof = 1'b0; vld = 1'b0; din = 8'h00;
  endtask

  task automatic run_one(input string req, input logic [47:0] a, input int gap);
    send(a, gap);
    check({req, " valid"}, dv, 1'b1);
    check(req, acc, ref_accept(a, mode, h_lo, h_hi));
    @(negedge clk);
    check("R2 single pulse", dv, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++; vectors++;
    $display("FAIL watchdog expired: got running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [47:0] a;
    int k;
    repeat (3) @(negedge clk);
    check("R1 reset valid", dv, 1'b0);
    check("R1 reset accept", acc, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle valid", dv, 1'b0);

    // R5/R6: hash decode over many multicast addresses
    for (int n = 0; n < 160; n++) begin
      next_rand(a);
      a[40] = 1'b1;
      if (&a) a[0] = 1'b0;
      k = ref_idx(a);
      {h_hi, h_lo} = 64'h1 << k;
      run_one("R5 own hash bit", a, n % 3);
      check("R5 own hash bit literal", acc, 1'b0); // pulse over: accept low
      {h_hi, h_lo} = 64'h1 << ((k + 1) % 64);
      run_one("R5 neighbour hash bit", a, 0);
      {h_hi, h_lo} = {64{1'b1}};
      run_one("R6 all-ones table", a, 0);
    end

    // R3/R4/R7/R8: every mode combination across address classes
    for (int m = 0; m < 8; m++) begin
      for (int hp = 0; hp < 2; hp++) begin
        mode = m[2:0];
        {h_hi, h_lo} = (hp == 0) ? 64'h0 : (64'h1 << ref_idx(OTHER));
        run_one("R4 broadcast", 48'hFFFF_FFFF_FFFF, 0);
        run_one("R3 station unicast", STATION, 1);
        run_one("R7 foreign unicast", OTHER, 0);
        run_one("R8 multicast under mode", MCAST, 0);
      end
    end

    // R4: broadcast ignores a full hash table when rejected
    mode = 3'b001; {h_hi, h_lo} = {64{1'b1}};
    send(48'hFFFF_FFFF_FFFF, 0);
    check("R4 reject with full table", acc, 1'b0);
    mode = 3'b101;
    @(negedge clk);
    send(48'hFFFF_FFFF_FFFF, 0);
    check("R8 promisc beats reject", acc, 1'b1);

    // R9: restart mid-address
    mode = 3'b000; {h_hi, h_lo} = 64'h0;
    @(negedge clk);
    sof = 1'b1; vld = 1'b1; din = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 partial quiet", dv, 1'b0);
      sof = 1'b0; din = 8'hEE;
    end
    send(STATION, 0);
    check("R9 restart valid", dv, 1'b1);
    check("R9 restart accept", acc, 1'b1);

    // R9: trailing valid bytes give no verdict
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i > 0) check("R9 trailing quiet", dv, 1'b0);
      sof = 1'b0; vld = 1'b1; din = STATION[47-8*(i%6) -: 8];
    end
    @(negedge clk);
    vld = 1'b0;
    check("R9 trailing quiet end", dv, 1'b0);
    @(negedge clk);
    check("R9 trailing quiet end2", dv, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule